// File: doc/BRIEF.md
# Processor Presence Bitmap

This block tracks which of up to 256 processor IDs are present. It stores one bit for each ID, packed eight to a byte, and software reads the map through a 32-byte window that it cannot write. Plug and unplug events arrive on a small event port, and each carries a processor ID. A plug event sets that ID's bit and an unplug event clears it. Every accepted event also latches the hotplug bit (bit 2) of the general-purpose event status byte. The event aggregator downstream uses that bit to decide whether to raise the system control interrupt.

At start-up, a one-cycle load strobe ORs a presence vector into the map. This records the processors that already exist without signalling an event. An event whose ID is past the end of the map is discarded, and a sticky error flag records it.

Top module: `cpu_hp_map`

## Requirements
- R1: After reset, every map bit is 0, `gpe_sts` is 8'h00, `id_err` is 0 and `rd_valid` is 0.
- R2: A read strobe (`rd_en`) in one cycle gives `rd_valid`=1 in the next cycle, with `rdata` holding the addressed byte as it stood before any update made in the strobe cycle.
- R3: Processor ID n is stored in byte n/8 of the window at bit position n%8.
- R4: A valid event with `ev_plug`=1 and an ID below 256 sets that ID's bit and leaves every other bit unchanged.
- R5: A valid event with `ev_plug`=0 and an ID below 256 clears that ID's bit and leaves every other bit unchanged.
- R6: Every valid event with an ID below 256 sets `gpe_sts` bit 2, the only bit of `gpe_sts` that is ever 1. The bit stays set until a cycle with `gpe_clr` bit 2 high and no such event; when a set and a clear arrive in the same cycle, the set wins.
- R7: Write strobes (`wr_en` with any address and `wdata`) change neither the map nor any output.
- R8: `init_load` ORs `init_map` into the map: it sets bits but never clears them, and never sets `gpe_sts` bit 2.
- R9: An event with an ID of 256 or more changes neither the map nor `gpe_sts`, and it sets `id_err`, which stays 1 until reset.
- R10: When `init_load` and a valid in-range event occur in the same cycle, the event decides the value of its own ID's bit.
- R11: Only the low 5 bits of `addr` select the byte; the upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_load | input | 1 | One-cycle strobe that ORs `init_map` into the map |
| init_map | input | 256 | Start-up presence vector, bit n for ID n |
| ev_valid | input | 1 | Hotplug event strobe |
| ev_plug | input | 1 | 1 = plug, 0 = unplug |
| ev_id | input | 9 | Processor ID of the event |
| gpe_clr | input | 8 | Write-one-to-clear mask for `gpe_sts` |
| rd_en | input | 1 | Window read strobe |
| wr_en | input | 1 | Window write strobe (ignored) |
| addr | input | 16 | Window byte address |
| wdata | input | 8 | Write data (ignored) |
| rdata | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | `rdata` holds a new read result |
| gpe_sts | output | 8 | Event status byte, bit 2 is the hotplug bit |
| id_err | output | 1 | Sticky flag for an out-of-range event ID |

## Verification
The checker observes the stored map on every cycle. It confirms that a plug or unplug leaves the addressed bit at 1 or 0, that a quiet cycle or a lone write leaves the map stable, that an out-of-range ID changes nothing but raises the error flag, and that the flag never falls. It also checks the one-cycle read latency and that a bare load does not raise the hotplug status bit. Some properties can be seen only through the bench's scenarios: the byte and bit layout read back through the window, the value a read returns when an event lands in the same cycle, the outcome of a clear that coincides with a set, a load that coincides with an unplug, and addresses with stray upper bits.

// File: rtl/cpu_hp_map.sv
module cpu_hp_map #(
  parameter int NUM_IDS = 256,
  parameter int ADDR_W  = 16,
  parameter int EVID_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_load,
  input  logic [NUM_IDS-1:0] init_map,
  input  logic               ev_valid,
  input  logic               ev_plug,
  input  logic [EVID_W-1:0]  ev_id,
  input  logic [7:0]         gpe_clr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               rd_valid,
  output logic [7:0]         gpe_sts,
  output logic               id_err
);
  localparam int BYTES = NUM_IDS / 8;
  localparam int AW    = $clog2(BYTES);
  localparam int IW    = $clog2(NUM_IDS);
  localparam int HP_BIT = 2;

  logic [NUM_IDS-1:0] map_q, map_d;
  logic               hp_q;
  logic               id_ok;
  logic [IW-1:0]      idx;
  logic [AW-1:0]      byte_sel;

  assign id_ok    = ev_id < EVID_W'(NUM_IDS);
  assign idx      = ev_id[IW-1:0];
  assign byte_sel = addr[AW-1:0];

  always_comb begin
    map_d = map_q | (init_load ? init_map : '0);
    if (ev_valid && id_ok) map_d[idx] = ev_plug;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q    <= '0;
      hp_q     <= 1'b0;
      id_err   <= 1'b0;
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      map_q    <= map_d;
      hp_q     <= (hp_q & ~gpe_clr[HP_BIT]) | (ev_valid & id_ok);
      id_err   <= id_err | (ev_valid & ~id_ok);
      rd_valid <= rd_en;
      if (rd_en) rdata <= map_q[byte_sel*8 +: 8];
    end
  end

  always_comb begin
    gpe_sts = '0;
    gpe_sts[HP_BIT] = hp_q;
  end

  logic unused_inputs;
  assign unused_inputs = ^{wr_en, wdata, addr[ADDR_W-1:AW], gpe_clr[7:HP_BIT+1], gpe_clr[HP_BIT-1:0]};
endmodule

// File: rtl/cpu_hp_map_chk.sv
module cpu_hp_map_chk #(
  parameter int NUM_IDS = 256,
  parameter int EVID_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_load,
  input logic               ev_valid,
  input logic               ev_plug,
  input logic [EVID_W-1:0]  ev_id,
  input logic               rd_en,
  input logic               rd_valid,
  input logic [NUM_IDS-1:0] map_q,
  input logic               hp_q,
  input logic               id_err
);
  localparam int IW = $clog2(NUM_IDS);
  logic in_rng;
  assign in_rng = ev_id < EVID_W'(NUM_IDS);

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_plug_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_plug && in_rng) |=> map_q[$past(ev_id[IW-1:0])] == 1'b1);
  p_unplug_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_plug && in_rng) |=> map_q[$past(ev_id[IW-1:0])] == 1'b0);
  p_event_gpe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && in_rng) |=> hp_q);
  p_quiet_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !init_load) |=> $stable(map_q));
  p_load_no_gpe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_load && !ev_valid && !hp_q) |=> !hp_q);
  p_drop_bad_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !in_rng && !init_load) |=> ($stable(map_q) && id_err));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |=> id_err);
endmodule

bind cpu_hp_map cpu_hp_map_chk #(.NUM_IDS(NUM_IDS), .EVID_W(EVID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_load(init_load), .ev_valid(ev_valid),
  .ev_plug(ev_plug), .ev_id(ev_id), .rd_en(rd_en), .rd_valid(rd_valid),
  .map_q(map_q), .hp_q(hp_q), .id_err(id_err)
);

// File: tb/cpu_hp_map_bench.sv
module cpu_hp_map_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         init_load = 0;
  logic [255:0] init_map = '0;
  logic         ev_valid = 0;
  logic         ev_plug = 0;
  logic [8:0]   ev_id = '0;
  logic [7:0]   gpe_clr = '0;
  logic         rd_en = 0;
  logic         wr_en = 0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         rd_valid;
  logic [7:0]   gpe_sts;
  logic         id_err;

  cpu_hp_map u_cpu_hp_map (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit [255:0] mdl = '0;
  bit         gpe_m = 0, err_m = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      rd_tag = "R2";
  bit         done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply the model for the inputs driven now, advance one cycle, drop strobes
  task automatic tick();
    bit [255:0] nxt;
    if (rd_en) begin
      exp_q.push_back(mdl[addr[4:0]*8 +: 8]);
      tag_q.push_back(rd_tag);
    end
    nxt = mdl | (init_load ? init_map : '0);
    if (ev_valid && ev_id < 256) nxt[ev_id[7:0]] = ev_plug;
    gpe_m = (gpe_m && !gpe_clr[2]) || (ev_valid && ev_id < 256);
    if (ev_valid && ev_id >= 256) err_m = 1;
    mdl = nxt;
    @(negedge clk);
    init_load = 0; ev_valid = 0; gpe_clr = '0; rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(logic [15:0] a, string req);
    rd_en = 1; addr = a; rd_tag = req;
    tick();
  endtask

  task automatic ev(bit plug, int id);
    ev_valid = 1; ev_plug = plug; ev_id = 9'(id);
    tick();
  endtask

  task automatic chk_side(string req);
    chk(gpe_sts == {5'b0, gpe_m, 2'b0}, req, gpe_sts, {5'b0, gpe_m, 2'b0});
    chk(id_err == err_m, req, id_err, err_m);
  endtask

  // monitor: compare read results in the cycle after the strobe
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gpe_sts == 0 && id_err == 0 && rd_valid == 0, "R1", {gpe_sts, id_err, rd_valid}, 0);
    rd(16'h0000, "R1"); rd(16'h001f, "R1");

    init_map = '0;
    init_map[0] = 1; init_map[1] = 1; init_map[9] = 1; init_map[255] = 1;
    init_load = 1; tick();
    chk_side("R8 load raises no gpe");
    rd(16'h0000, "R8"); rd(16'h0001, "R8"); rd(16'h001f, "R8");

    ev(1, 17);
    chk_side("R6 plug sets gpe bit2");
    rd(16'h0002, "R3 R4 id17 byte2 bit1");
    gpe_clr = 8'h04; tick();
    chk_side("R6 clear");
    ev(0, 1);
    rd(16'h0000, "R5 unplug id1");
    ev(0, 255);
    rd(16'h001f, "R5 unplug id255");
    gpe_clr = 8'h04; tick();

    wr_en = 1; addr = 16'h0002; wdata = 8'hff; tick();
    wr_en = 1; addr = 16'h0000; wdata = 8'h00; tick();
    chk_side("R7 write no side effect");
    rd(16'h0002, "R7"); rd(16'h0000, "R7");

    ev(1, 300);
    chk_side("R9 bad id sets err no gpe");
    repeat (3) tick();
    chk_side("R9 err sticky");
    rd(16'h0002, "R9 map unchanged");

    init_map = '0; init_map[40] = 1; init_map[41] = 1;
    init_load = 1; ev_valid = 1; ev_plug = 0; ev_id = 9'd40; tick();
    rd(16'h0005, "R10 event wins over load");
    init_map = '0; init_map[42] = 1;
    init_load = 1; tick();
    rd(16'h0005, "R8 load never clears");

    ev_valid = 1; ev_plug = 1; ev_id = 9'd100; gpe_clr = 8'h04; tick();
    chk_side("R6 set wins over clear");
    gpe_clr = 8'hfb; tick();
    chk_side("R6 other clear bits no effect");

    rd(16'hbee5, "R11 upper addr ignored");
    rd(16'h0fec, "R11 upper addr ignored");

    rd_en = 1; addr = 16'h0006; rd_tag = "R2 old value on same-cycle event";
    ev_valid = 1; ev_plug = 1; ev_id = 9'd50; tick();
    rd(16'h0006, "R2 new value after event");

    for (int k = 0; k < 32; k++) ev(1, k * 9 % 256);
    for (int k = 0; k < 32; k += 3) ev(0, k * 8 + 7);
    for (int a = 0; a < 32; a++) rd(16'(a), "R3 full map");
    chk_side("R6 after sweep");

    repeat (3) tick();
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule